// File: doc/BRIEF.md
# Sticky Interrupt Status Register

This block turns a vector of hardware event lines into a register of interrupt status bits. A detector watches each line and reports a hit on one of four conditions: the line is high, it rises, it falls, or it changes either way. A capture stage then records the hits in one of three ways. Each bit can latch on its own. The whole hit vector can be frozen the first time it is nonzero. Or the status can simply follow the hits from cycle to cycle. Software clears recorded bits by writing ones to their positions.

Two reduction outputs are built from the status. One is the interrupt line and the other is the halt line. Each has its own per-bit select vector. A build parameter decides whether a select bit of 1 admits the bit (enable sense) or blocks it (mask sense). The detection and capture modes are inputs, so one instance can be switched between them at run time.

Top module: `sticky_irq_status`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `status` is all zeros and `irq` and `halt` are 0. The stored copy of the previous input resets to zero, so in the first cycle a high input counts as a rising edge and never as a falling edge.
- R2: With `det_sel` = 0 (level), every bit of `evt_in` that is 1 in a cycle is a hit for that cycle.
- R3: With `det_sel` = 1 (rising), a bit is a hit when it is 1 now and was 0 in the previous cycle.
- R4: With `det_sel` = 2 (falling), a bit is a hit when it is 0 now and was 1 in the previous cycle.
- R5: With `det_sel` = 3 (either edge), a bit is a hit when its value differs from the previous cycle.
- R6: With `cap_sel` = 0 (per-bit sticky), a hit sets its status bit on the next clock edge. The bit then stays 1 until a clear addresses it.
- R7: In per-bit sticky mode, if a hit and a clear reach the same bit in the same cycle, the bit is 1 afterwards.
- R8: With `cap_sel` = 1 (whole-value sticky), the whole hit vector is loaded when the status, after this cycle's clear, is zero and the hit vector is nonzero. Otherwise the status keeps its value minus any cleared bits.
- R9: With `cap_sel` = 2 or 3 (non-sticky), the status on each edge equals the hit vector of the previous cycle, and clears have no effect.
- R10: `irq` is the OR of `status & irq_sel`. With the default parameter, a select bit of 1 enables that bit.
- R11: `halt` is the OR of `status & ~halt_sel`. With the default parameter, a select bit of 1 masks that bit.
- R12: A clear takes effect only when `clr_we` is 1, and it affects only the bits where `clr_data` is 1. In sticky modes, `clr_we` = 0 leaves the status unchanged except for new hits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_in | input | WIDTH | Hardware event lines |
| det_sel | input | 2 | Detection: 0 level, 1 rising, 2 falling, 3 either edge |
| cap_sel | input | 2 | Capture: 0 per-bit sticky, 1 whole-value sticky, 2/3 non-sticky |
| clr_we | input | 1 | Software clear strobe |
| clr_data | input | WIDTH | Write-one-to-clear bit pattern |
| irq_sel | input | WIDTH | Interrupt select vector (enable or mask by parameter) |
| halt_sel | input | WIDTH | Halt select vector (enable or mask by parameter) |
| status | output | WIDTH | Recorded status bits |
| irq | output | 1 | Interrupt reduction output |
| halt | output | 1 | Halt reduction output |

## Verification
A detected hit and a software clear can land on the same status bit in the same cycle. In per-bit mode the hit must win. In whole-value mode a clear that empties the register lets a same-cycle hit vector load at once. The bench provokes this on purpose: it holds a level input high while writing ones to the same position. Throughout a pseudo-random sweep of every detection and capture pairing, it also overlaps clears with events. Each result is judged against a bench model that rebuilds the status every cycle from the hit rule and the write-one-to-clear rule.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

  typedef enum logic [1:0] {
    DET_LEVEL = 2'd0,
    DET_RISE  = 2'd1,
    DET_FALL  = 2'd2,
    DET_ANY   = 2'd3
  } det_mode_e;

  typedef enum logic [1:0] {
    CAP_PERBIT = 2'd0,
    CAP_WHOLE  = 2'd1,
    CAP_LIVE   = 2'd2,
    CAP_LIVE_B = 2'd3
  } cap_mode_e;

  localparam bit SEL_ENABLE = 1'b0;
  localparam bit SEL_MASK   = 1'b1;

endpackage

// File: rtl/sirq_edge_detect.sv
module sirq_edge_detect
  import sirq_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] evt_in,
  input  det_mode_e        mode,
  output logic [WIDTH-1:0] hit
);

  logic [WIDTH-1:0] prev_q;

  function automatic logic [WIDTH-1:0] find_hits(
    input logic [WIDTH-1:0] cur,
    input logic [WIDTH-1:0] old,
    input det_mode_e        m
  );
    case (m)
      DET_RISE: find_hits = cur & ~old;
      DET_FALL: find_hits = ~cur & old;
      DET_ANY:  find_hits = cur ^ old;
      default:  find_hits = cur;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= evt_in;
  end

  assign hit = find_hits(evt_in, prev_q, mode);

  // R3
  rise_only_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == DET_RISE) |-> ((hit & ~evt_in) == '0));

  // R4
  fall_only_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == DET_FALL) |-> ((hit & evt_in) == '0));

endmodule

// File: rtl/sirq_capture.sv
module sirq_capture
  import sirq_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] hit,
  input  cap_mode_e        mode,
  input  logic             clr_we,
  input  logic [WIDTH-1:0] clr_data,
  output logic [WIDTH-1:0] status,
  output logic [WIDTH-1:0] clr_mask
);

  logic [WIDTH-1:0] status_q;
  logic [WIDTH-1:0] status_d;
  logic [WIDTH-1:0] kept;

  function automatic logic [WIDTH-1:0] next_status(
    input logic [WIDTH-1:0] remain,
    input logic [WIDTH-1:0] h,
    input cap_mode_e        m
  );
    case (m)
      CAP_PERBIT: next_status = remain | h;
      CAP_WHOLE:  next_status = (remain == '0 && h != '0) ? h : remain;
      default:    next_status = h;
    endcase
  endfunction

  assign clr_mask = clr_we ? clr_data : '0;
  assign kept     = status_q & ~clr_mask;
  assign status_d = next_status(kept, hit, mode);

  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end

  assign status = status_q;

  // R6
  perbit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CAP_PERBIT && clr_mask == '0) |=>
      ((status_q & $past(status_q)) == $past(status_q)));

  // R7
  hit_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CAP_PERBIT) |=> ((status_q & $past(hit)) == $past(hit)));

  // R8
  whole_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CAP_WHOLE && status_q != '0 && clr_mask == '0) |=> $stable(status_q));

  // R9
  live_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CAP_LIVE || mode == CAP_LIVE_B) |=> (status_q == $past(hit)));

endmodule

// File: rtl/sirq_reduce.sv
module sirq_reduce
  import sirq_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter bit POL   = SEL_ENABLE
) (
  input  logic [WIDTH-1:0] bits,
  input  logic [WIDTH-1:0] sel,
  output logic             out
);

  logic [WIDTH-1:0] admitted;

  generate
    if (POL == SEL_MASK) begin : g_mask
      assign admitted = bits & ~sel;
    end else begin : g_enable
      assign admitted = bits & sel;
    end
  endgenerate

  assign out = |admitted;

endmodule

// File: rtl/sticky_irq_status.sv
module sticky_irq_status
  import sirq_pkg::*;
#(
  parameter int WIDTH    = 8,
  parameter bit IRQ_POL  = SEL_ENABLE,
  parameter bit HALT_POL = SEL_MASK
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] evt_in,
  input  logic [1:0]       det_sel,
  input  logic [1:0]       cap_sel,
  input  logic             clr_we,
  input  logic [WIDTH-1:0] clr_data,
  input  logic [WIDTH-1:0] irq_sel,
  input  logic [WIDTH-1:0] halt_sel,
  output logic [WIDTH-1:0] status,
  output logic             irq,
  output logic             halt
);

  det_mode_e        det_mode;
  cap_mode_e        cap_mode;
  logic [WIDTH-1:0] hit;
  logic [WIDTH-1:0] clr_mask;

  assign det_mode = det_mode_e'(det_sel);
  assign cap_mode = cap_mode_e'(cap_sel);

  sirq_edge_detect #(.WIDTH(WIDTH)) u_det (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .mode(det_mode), .hit(hit)
  );

  sirq_capture #(.WIDTH(WIDTH)) u_cap (
    .clk(clk), .rst_n(rst_n), .hit(hit), .mode(cap_mode),
    .clr_we(clr_we), .clr_data(clr_data), .status(status), .clr_mask(clr_mask)
  );

  sirq_reduce #(.WIDTH(WIDTH), .POL(IRQ_POL)) u_irq (
    .bits(status), .sel(irq_sel), .out(irq)
  );

  sirq_reduce #(.WIDTH(WIDTH), .POL(HALT_POL)) u_halt (
    .bits(status), .sel(halt_sel), .out(halt)
  );

  // R10
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status == '0) |-> !irq);

  // R11
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status == '0) |-> !halt);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (status == '0));

endmodule

// File: tb/sticky_irq_status_tb.sv
`timescale 1ns/100ps
module sticky_irq_status_tb;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] evt_in = '0;
  logic [1:0]   det_sel = 2'd0;
  logic [1:0]   cap_sel = 2'd0;
  logic         clr_we = 1'b0;
  logic [W-1:0] clr_data = '0;
  logic [W-1:0] irq_sel = '0;
  logic [W-1:0] halt_sel = '0;
  logic [W-1:0] status;
  logic         irq;
  logic         halt;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  logic [W-1:0] m_prev;
  logic [W-1:0] m_stat;
  logic [15:0]  lfsr = 16'hACE1;

  string det_tag [4] = '{"R2", "R3", "R4", "R5"};
  string cap_tag [4] = '{"R6", "R8", "R9", "R9"};

  always #2.5 clk = ~clk;

  sticky_irq_status #(.WIDTH(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .det_sel(det_sel),
    .cap_sel(cap_sel), .clr_we(clr_we), .clr_data(clr_data),
    .irq_sel(irq_sel), .halt_sel(halt_sel),
    .status(status), .irq(irq), .halt(halt)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Bench model of one clock edge, written from the requirements.
  task automatic model_edge();
    logic [W-1:0] h;
    logic [W-1:0] wipe;
    logic [W-1:0] left;
    if (det_sel == 2'd0)      h = evt_in;
    else if (det_sel == 2'd1) h = evt_in & ~m_prev;
    else if (det_sel == 2'd2) h = m_prev & ~evt_in;
    else                      h = evt_in ^ m_prev;
    wipe = clr_we ? clr_data : '0;
    left = m_stat & ~wipe;
    if (cap_sel == 2'd0)      m_stat = left | h;
    else if (cap_sel == 2'd1) m_stat = (left == '0 && h != '0) ? h : left;
    else                      m_stat = h;
    m_prev = evt_in;
  endtask

  task automatic cycle();
    model_edge();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    evt_in = '0; clr_we = 1'b0; clr_data = '0;
    repeat (2) @(posedge clk);
    #1;
    check("R1 status in reset", status, '0);
    check("R1 irq/halt in reset", {6'd0, irq, halt}, '0);
    @(negedge clk);
    rst_n = 1'b1;
    m_prev = '0;
    m_stat = '0;
  endtask

  task automatic check_outputs(input string tag);
    check(tag, status, m_stat);
    check("R10 irq", {7'd0, irq}, {7'd0, |(m_stat & irq_sel)});
    check("R11 halt", {7'd0, halt}, {7'd0, |(m_stat & ~halt_sel)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    m_prev = '0;
    m_stat = '0;

    // R1: first cycle after reset with input high is a rise, never a fall
    det_sel = 2'd2; cap_sel = 2'd0;
    do_reset();
    evt_in = 8'hFF;
    cycle();
    check("R1 no false fall", status, 8'h00);
    det_sel = 2'd1;
    do_reset();
    evt_in = 8'h3C;
    cycle();
    check("R1 rise from reset", status, 8'h3C);

    // R7: hit and clear on the same bit; R12: clear only with strobe
    det_sel = 2'd0; cap_sel = 2'd0;
    do_reset();
    @(negedge clk); evt_in = 8'h81; cycle();
    check("R6 set", status, 8'h81);
    @(negedge clk); evt_in = 8'h01; clr_we = 1'b1; clr_data = 8'h81; cycle();
    check("R7 hit wins over clear", status, 8'h01);
    @(negedge clk); evt_in = 8'h00; clr_we = 1'b0; clr_data = 8'hFF; cycle();
    check("R12 no strobe no clear", status, 8'h01);
    @(negedge clk); clr_we = 1'b1; clr_data = 8'h02; cycle();
    check("R12 clear other bit only", status, 8'h01);
    @(negedge clk); clr_data = 8'h01; cycle();
    check("R12 clear addressed bit", status, 8'h00);
    clr_we = 1'b0;

    // Sweep every detection and capture mode with pseudo-random stimulus
    for (int d = 0; d < 4; d++) begin
      for (int c = 0; c < 4; c++) begin
        det_sel = d[1:0];
        cap_sel = c[1:0];
        irq_sel  = 8'h0F ^ {d[1:0], c[1:0], d[1:0], c[1:0]};
        halt_sel = 8'hF0 ^ {c[1:0], d[1:0], c[1:0], d[1:0]};
        do_reset();
        for (int k = 0; k < 60; k++) begin
          @(negedge clk);
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          evt_in   = (k % 4 == 0) ? lfsr[7:0] & lfsr[15:8] : lfsr[7:0];
          clr_we   = lfsr[9] & lfsr[3];
          clr_data = (k % 7 == 0) ? 8'hFF : lfsr[15:8];
          cycle();
          check_outputs({det_tag[d], "/", cap_tag[c]});
        end
        clr_we = 1'b0;
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule